// File: doc/BRIEF.md
# Single-Cycle Processor Core with Register-Indexed Load

A compact 32-bit single-cycle core built around a program counter, a 32-entry register file, one ALU, a sign extender, a main decoder and an ALU function decoder. It runs a small instruction subset: the R-type operations add, sub, and, or and slt, plus word load, word store, branch-on-equal and jump. It also runs one extra R-type instruction, a register-indexed load. That load takes its address from the sum of two registers and writes the loaded word to the rd register. It uses the same adder that forms ordinary load and store addresses, so no second address adder is added.

Instruction and data storage are internal word arrays. The testbench fills them before it releases reset. Every instruction finishes in the clock cycle in which it is shown. The core exposes the current PC and instruction, the register write (enable, index, data) and the data-memory write (enable, address, data). These are its only view to the outside.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the PC is 0 and every register reads 0. The first instruction after release is fetched from address 0.
- R2: R-type (opcode 000000) with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or and 0x2A signed slt writes the ALU result to register rd (bits 15:11).
- R3: Load word (opcode 0x23) writes mem[rs + sign-extended imm] to register rt (bits 20:16). The word index is address bits [AW+1:2].
- R4: Store word (opcode 0x2B) writes register rt to mem[rs + sign-extended imm], and writes no register.
- R5: Register-indexed load (opcode 000000, funct 0x3F) writes mem[rs + rt] to rd and does not write data memory.
- R6: Only funct 0x3F selects the memory result in R-type format. Every other R-type writes the ALU result and never the memory word at that address.
- R7: Branch-on-equal (opcode 0x04) moves the PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise.
- R8: Jump (opcode 0x02) moves the PC to {PC+4[31:28], imm26, 2'b00}.
- R9: Register 0 always reads as 0, and writes to it have no effect.
- R10: Every instruction completes in one cycle. Instructions other than taken branches and jumps advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Address of the current instruction |
| instr_o | output | 32 | Current instruction word |
| rf_we_o | output | 1 | Register write control of the current instruction |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Data written to the register file |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-memory write data |

## Verification
The register-indexed load reads its source registers in the same cycle that it writes its destination. When the destination is also one of the sources, the address must come from the old value. The bench provokes this with a load whose rd equals rs. It expects the word at the address formed from the old registers, and then stores the result back to confirm what was committed. The bench also runs the indexed load and an ordinary add on the same register pair, and judges that one returns memory data and the other returns the sum.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_LDX  = 6'h3F;

  localparam logic [1:0] AOP_ADD = 2'b00;
  localparam logic [1:0] AOP_SUB = 2'b01;
  localparam logic [1:0] AOP_FN  = 2'b10;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic       reg_dst;
    logic       jump;
    logic       branch;
    logic       mem_read;
    logic       mem_to_reg;
    logic [1:0] alu_op;
    logic       mem_write;
    logic       alu_src;
    logic       reg_write;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        if (funct_i == FN_LDX) begin
          // indexed load: rs+rt through the shared adder, memory to rd
          ctrl_o.mem_read   = 1'b1;
          ctrl_o.mem_to_reg = 1'b1;
          ctrl_o.alu_op     = AOP_ADD;
        end else begin
          ctrl_o.alu_op     = AOP_FN;
        end
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_op     = AOP_ADD;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_op    = AOP_ADD;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = AOP_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ctrl_o = '0;
    endcase
  end

  always_comb begin
    alu_fn_o = ALU_ADD;
    case (ctrl_o.alu_op)
      AOP_SUB: alu_fn_o = ALU_SUB;
      AOP_FN: begin
        case (funct_i)
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: alu_fn_o = ALU_ADD;
        endcase
      end
      default: alu_fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int IDXW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] ra_i,
  input  logic [IDXW-1:0] rb_i,
  output logic [W-1:0]    a_o,
  output logic [W-1:0]    b_o,
  input  logic            we_i,
  input  logic [IDXW-1:0] wa_i,
  input  logic [W-1:0]    wd_i
);
  localparam int N = 1 << IDXW;

  logic [W-1:0] regs_q [N];

  assign regs_q[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (we_i && wa_i == IDXW'(g))              regs_q[g] <= wd_i;
    end
  end

  assign a_o = regs_q[ra_i];
  assign b_o = regs_q[rb_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = re_i ? mem_q[idx_i] : '0;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o,
  output logic            rf_we_o,
  output logic [RIDX-1:0] rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target, j_target;
  logic [XLEN-1:0] instr, rs_val, rt_val, imm_ext, alu_b, alu_y, ld_data, wb_data;
  logic [RIDX-1:0] waddr;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic            zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  sc_mem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk_i   (clk_i),
    .re_i    (1'b1),
    .we_i    (1'b0),
    .idx_i   (pc_q[IAW+1:2]),
    .wdata_i ('0),
    .rdata_o (instr)
  );

  sc_ctrl u_ctrl (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl),
    .alu_fn_o (alu_fn)
  );

  assign waddr = ctrl.reg_dst ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .IDXW(RIDX)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[25:21]),
    .rb_i   (instr[20:16]),
    .a_o    (rs_val),
    .b_o    (rt_val),
    .we_i   (ctrl.reg_write),
    .wa_i   (waddr),
    .wd_i   (wb_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.alu_src ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .fn_i   (alu_fn),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (zero)
  );

  sc_mem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk_i   (clk_i),
    .re_i    (ctrl.mem_read),
    .we_i    (ctrl.mem_write),
    .idx_i   (alu_y[DAW+1:2]),
    .wdata_i (rt_val),
    .rdata_o (ld_data)
  );

  assign wb_data   = ctrl.mem_to_reg ? ld_data : alu_y;

  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                pc_next = j_target;
    else if (ctrl.branch && zero) pc_next = br_target;
    else                          pc_next = pc_plus4;
  end

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.reg_write;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctrl.mem_write;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dm_we_o
);
  logic        armed_q;
  logic [31:0] pc4;
  logic [5:0]  op, fn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign pc4 = pc_o + 32'd4;
  assign op  = instr_o[31:26];
  assign fn  = instr_o[5:0];

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_pc_zero: assert (pc_o == 32'd0);
  end

  a_r10_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && op != OP_BEQ && op != OP_J) |=> pc_o == $past(pc4));

  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && op == OP_J) |=> pc_o == {$past(pc4[31:28]), $past(instr_o[25:0]), 2'b00});

  a_r5_ldx_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && fn == FN_LDX) |-> (!dm_we_o && rf_we_o && rf_waddr_o == instr_o[15:11]));

  a_r4_store_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (dm_we_o && !rf_we_o));

  a_r6_rtype_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE) |-> (!dm_we_o && rf_waddr_o == instr_o[15:11]));

  a_r10_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, dm_we_o}));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_o       (pc_o),
  .instr_o    (instr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  sc_core u_dut (
    .clk_i, .rst_ni, .pc_o, .instr_o, .rf_we_o, .rf_waddr_o,
    .rf_wdata_o, .dm_we_o, .dm_addr_o, .dm_wdata_o
  );

  function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_op(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_wb(input string req, input int idx, input logic [31:0] val);
    chk(req, "rf_we", 32'(rf_we_o), 32'd1);
    chk(req, "rf_waddr", 32'(rf_waddr_o), 32'(idx));
    chk(req, "rf_wdata", rf_wdata_o, val);
  endtask

  task automatic nxt();
    @(negedge clk_i);
  endtask

  task automatic hold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      u_dut.u_imem.mem_q[i] = 32'd0;
      u_dut.u_dmem.mem_q[i] = 32'd0;
    end
  endtask

  task automatic release_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0;
  endtask

  task automatic t_reset();
    hold_reset();
    u_dut.u_imem.mem_q[0] = i_op(6'h2B, 0, 5, 16'd4);
    @(negedge clk_i);
    chk("R1", "pc in reset", pc_o, 32'd0);
    release_reset();
    chk("R1", "pc after release", pc_o, 32'd0);
    chk("R1", "reg reads zero", dm_wdata_o, 32'd0);
    chk("R4", "store strobe", 32'(dm_we_o), 32'd1);
    chk("R4", "store addr", dm_addr_o, 32'd4);
  endtask

  task automatic t_alu();
    hold_reset();
    u_dut.u_dmem.mem_q[0] = 32'd7;
    u_dut.u_dmem.mem_q[1] = 32'd5;
    u_dut.u_imem.mem_q[0] = i_op(6'h23, 0, 1, 16'd0);
    u_dut.u_imem.mem_q[1] = i_op(6'h23, 0, 2, 16'd4);
    u_dut.u_imem.mem_q[2] = rt_op(1, 2, 3, 6'h20);
    u_dut.u_imem.mem_q[3] = rt_op(1, 2, 4, 6'h22);
    u_dut.u_imem.mem_q[4] = rt_op(1, 2, 5, 6'h24);
    u_dut.u_imem.mem_q[5] = rt_op(1, 2, 6, 6'h25);
    u_dut.u_imem.mem_q[6] = rt_op(2, 1, 7, 6'h2A);
    u_dut.u_imem.mem_q[7] = rt_op(1, 2, 8, 6'h2A);
    u_dut.u_imem.mem_q[8] = rt_op(2, 1, 9, 6'h22);
    u_dut.u_imem.mem_q[9] = rt_op(9, 0, 10, 6'h2A);
    release_reset();
    chk_wb("R3", 1, 32'd7);             nxt();
    chk_wb("R3", 2, 32'd5);             nxt();
    chk_wb("R2", 3, 32'd12);            nxt();
    chk_wb("R2", 4, 32'd2);             nxt();
    chk_wb("R2", 5, 32'd5);             nxt();
    chk_wb("R2", 6, 32'd7);             nxt();
    chk_wb("R2", 7, 32'd1);             nxt();
    chk_wb("R2", 8, 32'd0);             nxt();
    chk_wb("R2", 9, 32'hFFFF_FFFE);     nxt();
    chk_wb("R2", 10, 32'd1);
    chk("R10", "pc after nine steps", pc_o, 32'd36);
  endtask

  task automatic t_ldx();
    hold_reset();
    u_dut.u_dmem.mem_q[0] = 32'd8;
    u_dut.u_dmem.mem_q[1] = 32'd12;
    u_dut.u_dmem.mem_q[5] = 32'hCAFE_0001;
    u_dut.u_imem.mem_q[0] = i_op(6'h23, 0, 1, 16'd0);
    u_dut.u_imem.mem_q[1] = i_op(6'h23, 0, 2, 16'd4);
    u_dut.u_imem.mem_q[2] = rt_op(1, 2, 3, 6'h3F);
    u_dut.u_imem.mem_q[3] = rt_op(1, 2, 4, 6'h20);
    u_dut.u_imem.mem_q[4] = rt_op(1, 2, 1, 6'h3F);
    u_dut.u_imem.mem_q[5] = i_op(6'h2B, 0, 1, 16'd24);
    u_dut.u_imem.mem_q[6] = i_op(6'h23, 0, 5, 16'd24);
    u_dut.u_imem.mem_q[7] = i_op(6'h23, 0, 6, 16'hFFFC + 16'd8);
    release_reset();
    nxt(); nxt();
    chk_wb("R5", 3, 32'hCAFE_0001);
    chk("R5", "no store", 32'(dm_we_o), 32'd0);
    chk("R5", "addr rs+rt", dm_addr_o, 32'd20);
    nxt();
    chk_wb("R6", 4, 32'd20);
    nxt();
    chk_wb("R5", 1, 32'hCAFE_0001);     nxt();
    chk("R4", "store data", dm_wdata_o, 32'hCAFE_0001);
    chk("R4", "store strobe", 32'(dm_we_o), 32'd1);
    chk("R4", "store no wb", 32'(rf_we_o), 32'd0);
    nxt();
    chk_wb("R4", 5, 32'hCAFE_0001);     nxt();
    chk_wb("R3", 6, 32'd12);
  endtask

  task automatic t_zero();
    hold_reset();
    u_dut.u_dmem.mem_q[0] = 32'h55;
    u_dut.u_imem.mem_q[0] = i_op(6'h23, 0, 0, 16'd0);
    u_dut.u_imem.mem_q[1] = i_op(6'h2B, 0, 0, 16'd8);
    u_dut.u_imem.mem_q[2] = i_op(6'h23, 0, 1, 16'd0);
    u_dut.u_imem.mem_q[3] = rt_op(1, 0, 2, 6'h20);
    release_reset();
    nxt();
    chk("R9", "r0 store data", dm_wdata_o, 32'd0);
    nxt(); nxt();
    chk_wb("R9", 2, 32'h55);
  endtask

  task automatic t_flow();
    hold_reset();
    u_dut.u_dmem.mem_q[0] = 32'd3;
    u_dut.u_dmem.mem_q[1] = 32'd3;
    u_dut.u_dmem.mem_q[2] = 32'd4;
    u_dut.u_imem.mem_q[0]  = i_op(6'h23, 0, 1, 16'd0);
    u_dut.u_imem.mem_q[1]  = i_op(6'h23, 0, 2, 16'd4);
    u_dut.u_imem.mem_q[2]  = i_op(6'h23, 0, 3, 16'd8);
    u_dut.u_imem.mem_q[3]  = i_op(6'h04, 1, 3, 16'd5);
    u_dut.u_imem.mem_q[4]  = i_op(6'h04, 1, 2, 16'd2);
    u_dut.u_imem.mem_q[7]  = {6'h02, 26'd12};
    u_dut.u_imem.mem_q[12] = i_op(6'h04, 0, 0, 16'hFFF3);
    release_reset();
    nxt(); nxt(); nxt();
    chk("R7", "at first beq", pc_o, 32'd12);
    chk("R7", "beq no wb", 32'(rf_we_o), 32'd0);
    nxt();
    chk("R7", "not taken", pc_o, 32'd16);
    nxt();
    chk("R7", "taken forward", pc_o, 32'd28);
    nxt();
    chk("R8", "jump target", pc_o, 32'd48);
    nxt();
    chk("R7", "taken backward", pc_o, 32'd0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_ldx();
    t_zero();
    t_flow();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule